// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is the circular result buffer at the centre of a speculative, out-of-order core. Every instruction that leaves the decode stage claims a slot at the young end of the ring. The slot number goes back to the scheduler as the tag under which the instruction's result will later appear. Execution units finish in any order and place each result on a shared result bus together with its tag. The matching slot latches the value and marks itself ready. Consumers whose producer has not yet retired read the value straight out of the producer's slot through a tag-addressed read port.

Architectural state changes only at the old end of the ring, one slot per cycle and strictly in program order. A register-class slot drives a register-file write. A store-class slot drives a memory write, with the destination field carrying the address. A branch-class slot leaves without side effects. A slot that completed with an exception raises a trap instead of retiring, and the whole ring is emptied. On a mispredicted branch, a flush names the branch's tag. Everything younger than that slot is dropped by moving the young end back, so undoing speculation costs a single cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty and not full, the allocation tag is 0, and no register write, memory write or trap is asserted.
- R2: An issue is accepted (`iss_ok` high) only when `iss_valid` and `iss_rs_free` are both high, the buffer is not full, and neither a flush nor a trap is active. The returned tag is the current young-end slot, and successive accepted issues receive consecutive tags modulo DEPTH.
- R3: After DEPTH accepted issues with nothing retired, `full` is high and further issue requests are refused.
- R4: A result presented with `res_valid` writes its value into the slot named by `res_tag` and marks that slot ready. From the following cycle the read port reports the slot as ready with that value.
- R5: A slot that has been allocated but has received no result reads back as not ready on the read port.
- R6: Retirement is strictly in program order: a ready slot waits as long as any older slot lacks its result.
- R7: The kind codes are 0 for register, 1 for store and 2 for branch. A register slot retires with `cm_reg_we` high and a store slot with `cm_mem_we` high, each carrying the slot's destination and value. A branch slot retires in one cycle with neither write asserted.
- R8: At most one slot retires per cycle. When several consecutive slots are ready, they retire in back-to-back cycles.
- R9: A result that arrives for the oldest slot does not cause retirement in the cycle it is presented. Retirement happens in the following cycle.
- R10: When the oldest slot is ready and carries the exception flag, `trap` is asserted for one cycle with no write. The buffer is empty in the next cycle, and the allocation tag is left unchanged.
- R11: A flush keeps every slot up to and including `flush_tag` and discards all younger slots, so the next allocation tag becomes `flush_tag + 1`. An issue request in the flush cycle is refused.
- R12: The ring indices wrap past DEPTH-1 to 0, and full is told apart from empty correctly across the wrap, including when a flush names a slot whose index lies numerically below the oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Request to allocate a slot |
| iss_rs_free | input | 1 | A scheduler entry is free for this instruction |
| iss_kind | input | 2 | Slot class: 0 register, 1 store, 2 branch |
| iss_dest | input | 8 | Register index or store address |
| iss_ok | output | 1 | Allocation accepted this cycle |
| iss_tag | output | IW | Tag of the slot being allocated |
| full | output | 1 | No free slot |
| empty | output | 1 | No occupied slot |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | IW | Slot the result belongs to |
| res_value | input | 32 | Result value |
| res_exc | input | 1 | Result completed with an exception |
| rd_tag | input | IW | Slot to read as an operand source |
| rd_ready | output | 1 | Read slot holds its result |
| rd_value | output | 32 | Value held by the read slot |
| flush | input | 1 | Discard slots younger than `flush_tag` |
| flush_tag | input | IW | Youngest slot to keep |
| cm_reg_we | output | 1 | Register-file write from the retiring slot |
| cm_mem_we | output | 1 | Memory write from the retiring slot |
| cm_dest | output | 8 | Destination of the retiring slot |
| cm_value | output | 32 | Value of the retiring slot |
| trap | output | 1 | Oldest slot completed with an exception |

## Verification
The assertions assume that a result is only ever broadcast for a slot that is currently occupied, and at most once per slot. They also assume that a flush names an occupied slot and that DEPTH is a power of two. The stimulus keeps to these assumptions by keeping a model queue of live tags: results are issued only for tags in that queue, flush targets are picked from it, and the queue is trimmed the same way the hardware is after every flush or trap. Out-of-order completion, wrap-around and flushes across the wrap are all generated within those limits.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
    localparam int ROB_DATA_W = 32;
    localparam int ROB_DEST_W = 8;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } rob_kind_e;

    typedef struct packed {
        rob_kind_e             kind;
        logic [ROB_DEST_W-1:0] dest;
        logic [ROB_DATA_W-1:0] value;
        logic                  ready;
        logic                  exc;
    } rob_entry_t;

    function automatic logic kind_writes_reg(rob_kind_e k);
        return k == KIND_REG;
    endfunction

    function automatic logic kind_writes_mem(rob_kind_e k);
        return k == KIND_STORE;
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          retire,
    input  logic          drop_all,
    input  logic          flush,
    input  logic [IW-1:0] flush_idx,
    output logic [IW-1:0] head_idx,
    output logic [IW-1:0] tail_idx,
    output logic          full,
    output logic          empty
);
    localparam int PW = IW + 1;

    logic [PW-1:0] head_q, tail_q, flush_ptr;

    assign head_idx = head_q[IW-1:0];
    assign tail_idx = tail_q[IW-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_idx == tail_idx) && (head_q[IW] != tail_q[IW]);

    // Slot kept by a flush lies on the same lap as the head unless its index wrapped below it.
    always_comb begin
        flush_ptr = {(flush_idx >= head_idx) ? head_q[IW] : ~head_q[IW], flush_idx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (drop_all) begin
            head_q <= tail_q;
        end else begin
            if (retire) head_q <= head_q + PW'(1);
            if (flush)      tail_q <= flush_ptr + PW'(1);
            else if (alloc) tail_q <= tail_q + PW'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !full) else $error("allocation into a full ring"); // R3
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
        (retire && !drop_all) |=> head_idx == $past(head_idx) + IW'(1)) else $error("head did not advance by one"); // R8
    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (rst)
        (flush && !drop_all) |=> tail_idx == $past(flush_idx) + IW'(1)) else $error("flush left wrong young end"); // R11
    AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        drop_all |=> empty) else $error("ring not empty after trap"); // R10
endmodule

// File: rtl/rob_entries.sv
`timescale 1ns/1ps
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc,
    input  logic [IW-1:0]         alloc_idx,
    input  rob_kind_e             alloc_kind,
    input  logic [ROB_DEST_W-1:0] alloc_dest,
    input  logic                  res_valid,
    input  logic [IW-1:0]         res_idx,
    input  logic [ROB_DATA_W-1:0] res_value,
    input  logic                  res_exc,
    input  logic [IW-1:0]         head_idx,
    input  logic [IW-1:0]         rd_idx,
    output rob_entry_t            head_ent,
    output rob_entry_t            rd_ent
);
    rob_entry_t ents [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (alloc && alloc_idx == IW'(i)) begin
                ents[i].kind  <= alloc_kind;
                ents[i].dest  <= alloc_dest;
                ents[i].value <= '0;
                ents[i].ready <= 1'b0;
                ents[i].exc   <= 1'b0;
            end else if (res_valid && res_idx == IW'(i)) begin
                ents[i].value <= res_value;
                ents[i].ready <= 1'b1;
                ents[i].exc   <= res_exc;
            end
        end
    end

    assign head_ent = ents[head_idx];
    assign rd_ent   = ents[rd_idx];

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && rd_idx == res_idx && !(alloc && alloc_idx == res_idx)) |=>
            ($stable(rd_idx) -> (rd_ent.ready && rd_ent.value == $past(res_value)))) else $error("result not captured"); // R4
endmodule

// File: rtl/rob_top.sv
`timescale 1ns/1ps
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  iss_valid,
    input  logic                  iss_rs_free,
    input  logic [1:0]            iss_kind,
    input  logic [ROB_DEST_W-1:0] iss_dest,
    output logic                  iss_ok,
    output logic [IW-1:0]         iss_tag,
    output logic                  full,
    output logic                  empty,
    input  logic                  res_valid,
    input  logic [IW-1:0]         res_tag,
    input  logic [ROB_DATA_W-1:0] res_value,
    input  logic                  res_exc,
    input  logic [IW-1:0]         rd_tag,
    output logic                  rd_ready,
    output logic [ROB_DATA_W-1:0] rd_value,
    input  logic                  flush,
    input  logic [IW-1:0]         flush_tag,
    output logic                  cm_reg_we,
    output logic                  cm_mem_we,
    output logic [ROB_DEST_W-1:0] cm_dest,
    output logic [ROB_DATA_W-1:0] cm_value,
    output logic                  trap
);
    logic [IW-1:0] head_idx, tail_idx;
    rob_entry_t    head_ent, rd_ent;
    logic          head_live, retire;

    assign head_live = !empty && head_ent.ready;
    assign trap      = head_live && head_ent.exc;
    assign retire    = head_live && !head_ent.exc;
    assign iss_ok    = iss_valid && iss_rs_free && !full && !flush && !trap;
    assign iss_tag   = tail_idx;

    assign cm_reg_we = retire && kind_writes_reg(head_ent.kind);
    assign cm_mem_we = retire && kind_writes_mem(head_ent.kind);
    assign cm_dest   = head_ent.dest;
    assign cm_value  = head_ent.value;
    assign rd_ready  = rd_ent.ready;
    assign rd_value  = rd_ent.value;

    rob_ptrs #(.DEPTH(DEPTH), .IW(IW)) u_ptrs (
        .clk(clk), .rst(rst), .alloc(iss_ok), .retire(retire), .drop_all(trap),
        .flush(flush), .flush_idx(flush_tag), .head_idx(head_idx), .tail_idx(tail_idx),
        .full(full), .empty(empty)
    );

    rob_entries #(.DEPTH(DEPTH), .IW(IW)) u_ents (
        .clk(clk), .rst(rst), .alloc(iss_ok), .alloc_idx(tail_idx),
        .alloc_kind(rob_kind_e'(iss_kind)), .alloc_dest(iss_dest),
        .res_valid(res_valid), .res_idx(res_tag), .res_value(res_value), .res_exc(res_exc),
        .head_idx(head_idx), .rd_idx(rd_tag), .head_ent(head_ent), .rd_ent(rd_ent)
    );

    AST_ISSUE_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
        iss_ok |=> iss_tag == $past(iss_tag) + IW'(1)) else $error("tags not consecutive"); // R2
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cm_reg_we, cm_mem_we, trap})) else $error("more than one retirement action"); // R8
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        empty |-> !(cm_reg_we || cm_mem_we || trap)) else $error("retirement from empty ring"); // R6
    AST_TRAP_KEEPS_TAIL: assert property (@(posedge clk) disable iff (rst)
        trap |=> iss_tag == $past(iss_tag)) else $error("trap moved the young end"); // R10
endmodule

// File: tb/sim_rob_top.sv
`timescale 1ns/1ps
module sim_rob_top;
    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 0, iss_rs_free = 0;
    logic [1:0]  iss_kind = 0;
    logic [7:0]  iss_dest = 0;
    logic        iss_ok, full, empty;
    logic [IW-1:0] iss_tag;
    logic        res_valid = 0, res_exc = 0;
    logic [IW-1:0] res_tag = 0, rd_tag = 0, flush_tag = 0;
    logic [31:0] res_value = 0;
    logic        rd_ready;
    logic [31:0] rd_value;
    logic        flush = 0;
    logic        cm_reg_we, cm_mem_we, trap;
    logic [7:0]  cm_dest;
    logic [31:0] cm_value;

    always #2.5 clk = ~clk;

    rob_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
        .iss_kind(iss_kind), .iss_dest(iss_dest), .iss_ok(iss_ok), .iss_tag(iss_tag),
        .full(full), .empty(empty), .res_valid(res_valid), .res_tag(res_tag),
        .res_value(res_value), .res_exc(res_exc), .rd_tag(rd_tag), .rd_ready(rd_ready),
        .rd_value(rd_value), .flush(flush), .flush_tag(flush_tag), .cm_reg_we(cm_reg_we),
        .cm_mem_we(cm_mem_we), .cm_dest(cm_dest), .cm_value(cm_value), .trap(trap)
    );

    typedef struct {
        logic [IW-1:0] tag;
        logic [1:0]    kind;
        logic [7:0]    dest;
        logic [31:0]   value;
        logic          exc;
    } exp_t;

    exp_t          expq[$];
    exp_t          mon_e;
    int            checks = 0;
    int            fails  = 0;
    logic [IW-1:0] next_tag = 0;
    bit            finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: every retirement action is compared against the oldest expected item.
    always @(negedge clk) begin
        if (!rst && (cm_reg_we || cm_mem_we || trap)) begin
            while (expq.size() > 0 && expq[0].kind == 2'd2) void'(expq.pop_front());
            if (expq.size() == 0) begin
                chk(1'b0, "R6 retirement with nothing outstanding", 1, 0);
            end else begin
                mon_e = expq.pop_front();
                if (trap) begin
                    chk(mon_e.exc == 1'b1, "R10 trap only for excepting head", trap, mon_e.exc);
                    expq.delete();
                end else begin
                    chk(cm_reg_we == (mon_e.kind == 2'd0) && cm_mem_we == (mon_e.kind == 2'd1) && !mon_e.exc,
                        "R7 write class matches kind", {cm_reg_we, cm_mem_we}, mon_e.kind);
                    chk(cm_dest == mon_e.dest && cm_value == mon_e.value,
                        "R6 in-order retirement payload", {cm_dest, cm_value}, {mon_e.dest, mon_e.value});
                end
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic [7:0] d);
        exp_t e;
        @(posedge clk); #1;
        iss_valid = 1; iss_rs_free = 1; iss_kind = k; iss_dest = d;
        @(negedge clk);
        chk(iss_ok == 1'b1, "R2 issue accepted", iss_ok, 1);
        chk(iss_tag == next_tag, "R2 tag is young-end slot", iss_tag, next_tag);
        e.tag = next_tag; e.kind = k; e.dest = d; e.value = '0; e.exc = 1'b0;
        expq.push_back(e);
        next_tag = next_tag + IW'(1);
        @(posedge clk); #1;
        iss_valid = 0;
    endtask

    task automatic result(input logic [IW-1:0] t, input logic [31:0] v, input logic x);
        @(posedge clk); #1;
        res_valid = 1; res_tag = t; res_value = v; res_exc = x;
        foreach (expq[i]) if (expq[i].tag == t) begin expq[i].value = v; expq[i].exc = x; end
        @(posedge clk); #1;
        res_valid = 0; res_exc = 0;
    endtask

    task automatic do_flush(input logic [IW-1:0] ft);
        @(posedge clk); #1;
        flush = 1; flush_tag = ft; iss_valid = 1; iss_rs_free = 1;
        @(negedge clk);
        chk(iss_ok == 1'b0, "R11 issue refused during flush", iss_ok, 0);
        @(posedge clk); #1;
        flush = 0; iss_valid = 0;
        while (expq.size() > 0 && expq[$].tag != ft) void'(expq.pop_back());
        next_tag = ft + IW'(1);
        @(negedge clk);
        chk(iss_tag == next_tag, "R11 next tag follows flushed slot", iss_tag, next_tag);
        chk(full == 1'b0, "R11 ring no longer full", full, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(empty == 1'b1 && full == 1'b0, "R1 empty after reset", {empty, full}, 2'b10);
        chk(iss_tag == 0, "R1 tag zero after reset", iss_tag, 0);
        chk(!cm_reg_we && !cm_mem_we && !trap, "R1 no retirement after reset", {cm_reg_we, cm_mem_we, trap}, 0);

        // Out-of-order completion, in-order retirement
        issue(2'd0, 8'h11);  // tag 0 reg
        issue(2'd1, 8'h22);  // tag 1 store
        issue(2'd2, 8'h33);  // tag 2 branch
        issue(2'd0, 8'h44);  // tag 3 reg
        result(4'd3, 32'hD003, 1'b0);
        result(4'd1, 32'hD001, 1'b0);
        result(4'd2, 32'hD002, 1'b0);
        @(negedge clk);
        chk(!cm_reg_we && !cm_mem_we, "R6 younger ready slots wait", {cm_reg_we, cm_mem_we}, 0);
        rd_tag = 4'd0;
        @(negedge clk);
        chk(rd_ready == 1'b0, "R5 pending slot not ready", rd_ready, 0);
        rd_tag = 4'd1;
        @(negedge clk);
        chk(rd_ready == 1'b1 && rd_value == 32'hD001, "R4 operand read of finished slot", rd_value, 32'hD001);

        // R9: result for head is not retired in its own cycle
        @(posedge clk); #1;
        res_valid = 1; res_tag = 4'd0; res_value = 32'hD000;
        expq[0].value = 32'hD000;
        @(negedge clk);
        chk(!cm_reg_we && !cm_mem_we, "R9 no retirement in result cycle", {cm_reg_we, cm_mem_we}, 0);
        @(posedge clk); #1;
        res_valid = 0;
        @(negedge clk);
        chk(cm_reg_we == 1'b1 && cm_dest == 8'h11, "R9 retirement one cycle later", {cm_reg_we, cm_dest}, 9'h111);
        @(negedge clk);
        chk(cm_mem_we == 1'b1 && cm_dest == 8'h22, "R8 store retires next cycle", {cm_mem_we, cm_dest}, 9'h122);
        @(negedge clk);
        chk(!cm_reg_we && !cm_mem_we && !empty, "R7 branch retires silently", {cm_reg_we, cm_mem_we, empty}, 0);
        @(negedge clk);
        chk(cm_reg_we == 1'b1 && cm_dest == 8'h44, "R8 back-to-back retirement", {cm_reg_we, cm_dest}, 9'h144);
        @(negedge clk);
        chk(empty == 1'b1, "R8 drained after four cycles", empty, 1);

        // R3 / R12: fill across the wrap
        for (int i = 0; i < DEPTH; i++) issue((i % 3 == 1) ? 2'd1 : 2'd0, 8'(8'h40 + i));
        @(negedge clk);
        chk(full == 1'b1 && empty == 1'b0, "R3 full after DEPTH issues", {full, empty}, 2'b10);
        @(posedge clk); #1;
        iss_valid = 1; iss_rs_free = 1;
        @(negedge clk);
        chk(iss_ok == 1'b0, "R3 issue refused when full", iss_ok, 1'b0);
        @(posedge clk); #1;
        iss_valid = 0;

        do_flush(4'd7);  // keep tags 4..7

        @(posedge clk); #1;
        iss_valid = 1; iss_rs_free = 0;
        @(negedge clk);
        chk(iss_ok == 1'b0, "R2 refused without free scheduler entry", iss_ok, 0);
        @(posedge clk); #1;
        iss_valid = 0;

        result(4'd5, 32'hE005, 1'b0);
        result(4'd6, 32'hE006, 1'b0);
        result(4'd7, 32'hE007, 1'b0);
        result(4'd4, 32'hE004, 1'b0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(empty == 1'b1 && expq.size() == 0, "R11 kept slots drained", empty, 1);

        // R12: flush whose target index lies below the head index
        for (int i = 0; i < 12; i++) issue(2'd0, 8'(8'h80 + i));  // tags 8..15, 0..3
        do_flush(4'd1);
        issue(2'd1, 8'hF2);  // tag 2
        for (int i = 0; i < 11; i++) begin
            logic [IW-1:0] t;
            t = IW'(2 - i);
            result(t, 32'hC000 + 32'(t), 1'b0);
        end
        repeat (14) @(posedge clk);
        @(negedge clk);
        chk(empty == 1'b1 && expq.size() == 0, "R12 wrapped flush drained", empty, 1);

        // R10: exception on the oldest slot
        issue(2'd0, 8'hA1);
        issue(2'd0, 8'hA2);
        result(next_tag - IW'(1), 32'hB002, 1'b0);
        @(posedge clk); #1;
        res_valid = 1; res_tag = next_tag - IW'(2); res_value = 32'hB001; res_exc = 1;
        expq[0].exc = 1'b1;
        @(posedge clk); #1;
        res_valid = 0; res_exc = 0;
        @(negedge clk);
        chk(trap == 1'b1 && !cm_reg_we && !cm_mem_we, "R10 trap without write", {trap, cm_reg_we, cm_mem_we}, 3'b100);
        @(negedge clk);
        chk(empty == 1'b1 && !trap, "R10 ring empty after trap", {empty, trap}, 2'b10);
        chk(iss_tag == next_tag, "R10 allocation tag unchanged", iss_tag, next_tag);

        finished = 1;
        summary();
    end
endmodule